// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Binary Counter

This block is a synchronous up-counter built from 4-bit stages that share one clock. All state bits update together on the rising edge, so the count never shows a partially updated value. An active-low clear forces the count to zero at once, with no clock needed. An active-low load copies the parallel data inputs into the count on the next rising edge.

Counting is gated by two enables. The shared enable `cnt_en_p` goes to every stage. The chained enable `cnt_en_t` goes only to the lowest stage. Each stage drives a carry signal that is high when its chained enable is high and its four bits are all ones. That carry is the chained enable of the next stage up, so the stages form one wider synchronous counter with no extra gating. The top module has `STAGES` stages; the default of two gives an 8-bit counter. The carry of the top stage is brought out so that more counters can be chained after it.

Top module: `sync_cnt_chain`

## Requirements
- R1: While `clear_n` is low, `q` is all zeros at once, without waiting for a clock edge. Clear takes priority over load and over both enables.
- R2: With `clear_n` high and `load_n` low, `q` takes the value of `din` at the next rising edge, whatever `cnt_en_p` and `cnt_en_t` are.
- R3: With `clear_n` and `load_n` high and both enables high, `q` increases by one at the rising edge. It wraps from all ones to zero.
- R4: With `clear_n` and `load_n` high and either enable low, `q` keeps its value across the rising edge.
- R5: `carry_out` is high exactly when `cnt_en_t` is high and every bit of `q` is 1. It is combinational, so it follows a change of `cnt_en_t` within the same cycle.
- R6: Each stage's chained enable is the carry of the stage below it. The upper 4-bit group therefore advances only on the edge where the lower group wraps from 15 to 0. The full 8-bit default counter steps from 0 through 255 and back to 0.
- R7: `q[0]` is the least significant bit of the count, and a load copies `din[i]` into `q[i]` for every i.
- R8: The enables are sampled only at the rising edge. A pulse on `cnt_en_p` between two edges, back at its old level before the next edge, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clear_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_en_p | input | 1 | Count enable shared by all stages |
| cnt_en_t | input | 1 | Count enable of the lowest stage; also gates the carry |
| din | input | STAGES*4 | Parallel load data, bit 0 least significant |
| q | output | STAGES*4 | Count value, bit 0 least significant |
| carry_out | output | 1 | Carry of the top stage, used to chain further counters |

## Verification
The assertions assume that `load_n`, both enables and `din` are stable around each rising edge. They also assume that `clear_n` is either held low across an edge or released well before one. Without this, the value sampled at the edge would not match the value the design acts on. The bench therefore changes every input just after a falling edge, or at a fixed offset inside the low phase, and never at a rising edge. The tests that pulse clear or an enable partway through a cycle do so in the half cycle before the next rising edge.

// File: rtl/sync_cnt_pkg.sv
package sync_cnt_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_COUNT = 2'd2
  } cnt_op_e;

endpackage

// File: rtl/sync_cnt_ctrl.sv
module sync_cnt_ctrl
  import sync_cnt_pkg::*;
(
  input  logic    load_n,
  input  logic    en_p,
  input  logic    en_t,
  output cnt_op_e op
);

  // load wins over both enables; counting needs both enables
  always_comb begin
    if (!load_n)            op = OP_LOAD;
    else if (en_p && en_t)  op = OP_COUNT;
    else                    op = OP_HOLD;
  end

endmodule

// File: rtl/sync_cnt_next.sv
module sync_cnt_next
  import sync_cnt_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  cnt_op_e        op,
  input  logic [W-1:0]   cur,
  input  logic [W-1:0]   load_val,
  output logic [W-1:0]   nxt,
  output logic           upd
);

  always_comb begin
    nxt = cur;
    upd = 1'b0;
    case (op)
      OP_LOAD: begin
        nxt = load_val;
        upd = 1'b1;
      end
      OP_COUNT: begin
        nxt = cur + W'(1);
        upd = 1'b1;
      end
      default: begin
        nxt = cur;
        upd = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/sync_cnt_stage.sv
module sync_cnt_stage
  import sync_cnt_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         clear_n,
  input  logic         load_n,
  input  logic         en_p,
  input  logic         en_t,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         carry
);

  cnt_op_e      op;
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;
  logic         upd;

  sync_cnt_ctrl u_ctrl (
    .load_n (load_n),
    .en_p   (en_p),
    .en_t   (en_t),
    .op     (op)
  );

  sync_cnt_next #(.W(W)) u_next (
    .op       (op),
    .cur      (q_r),
    .load_val (din),
    .nxt      (q_nxt),
    .upd      (upd)
  );

  // state register with written-out clock enable
  always_ff @(posedge clk or negedge clear_n) begin
    if (!clear_n)  q_r <= '0;
    else if (upd)  q_r <= q_nxt;
  end

  // carry is fed forward from the chained enable only
  always_comb carry = en_t & (&q_r);

  assign q = q_r;

  // R1: clear holds the count at zero at every edge it covers
  p_clear_zero_r1: assert property (@(posedge clk)
    !clear_n |-> (q_r == '0));

  // R2: load copies data regardless of the enables
  p_load_data_r2: assert property (@(posedge clk) disable iff (!clear_n)
    !load_n |=> (q_r == $past(din)));

  // R3: enabled increment with wrap
  p_count_up_r3: assert property (@(posedge clk) disable iff (!clear_n)
    (load_n && en_p && en_t) |=> (q_r == W'($past(q_r) + W'(1))));

  // R4: either enable low holds the count
  p_hold_r4: assert property (@(posedge clk) disable iff (!clear_n)
    (load_n && !(en_p && en_t)) |=> $stable(q_r));

  // R5: carry only at all ones with the chained enable high
  p_carry_full_r5: assert property (@(posedge clk) disable iff (!clear_n)
    carry |-> (en_t && (q_r == {W{1'b1}})));

endmodule

// File: rtl/sync_cnt_chain.sv
module sync_cnt_chain #(
  parameter int unsigned STAGES  = 2,
  parameter int unsigned STAGE_W = 4
) (
  input  logic                        clk,
  input  logic                        clear_n,
  input  logic                        load_n,
  input  logic                        cnt_en_p,
  input  logic                        cnt_en_t,
  input  logic [STAGES*STAGE_W-1:0]   din,
  output logic [STAGES*STAGE_W-1:0]   q,
  output logic                        carry_out
);

  localparam int unsigned TOT_W = STAGES * STAGE_W;

  // link[k] is the chained enable of stage k; link[STAGES] is the top carry
  logic [STAGES:0] link;

  assign link[0] = cnt_en_t;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    sync_cnt_stage #(.W(STAGE_W)) u_stage (
      .clk     (clk),
      .clear_n (clear_n),
      .load_n  (load_n),
      .en_p    (cnt_en_p),
      .en_t    (link[k]),
      .din     (din[k*STAGE_W +: STAGE_W]),
      .q       (q[k*STAGE_W +: STAGE_W]),
      .carry   (link[k+1])
    );
  end

  assign carry_out = link[STAGES];

  // R6: the chain counts as one wide counter when enabled
  p_chain_count_r6: assert property (@(posedge clk) disable iff (!clear_n)
    (load_n && cnt_en_p && cnt_en_t) |=> (q == TOT_W'($past(q) + TOT_W'(1))));

  // R6: the top carry marks a full chain with the entry enable high
  p_chain_carry_r6: assert property (@(posedge clk) disable iff (!clear_n)
    carry_out |-> (cnt_en_t && (q == {TOT_W{1'b1}})));

endmodule

// File: tb/sync_cnt_chain_tb_top.sv
module sync_cnt_chain_tb_top;

  localparam int unsigned STAGES  = 2;
  localparam int unsigned STAGE_W = 4;
  localparam int unsigned TW      = STAGES * STAGE_W;
  localparam int unsigned NVEC    = 12;

  logic          clk;
  logic          clear_n;
  logic          load_n;
  logic          cnt_en_p;
  logic          cnt_en_t;
  logic [TW-1:0] din;
  logic [TW-1:0] q;
  logic          carry_out;

  int errors = 0;
  int checks = 0;

  sync_cnt_chain #(.STAGES(STAGES), .STAGE_W(STAGE_W)) dut_i (
    .clk       (clk),
    .clear_n   (clear_n),
    .load_n    (load_n),
    .cnt_en_p  (cnt_en_p),
    .cnt_en_t  (cnt_en_t),
    .din       (din),
    .q         (q),
    .carry_out (carry_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // vector: clear_n, load_n, en_p, en_t, din[7:0], expected q[7:0], expected carry
  localparam logic [20:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0},  // R1 clear
    {1'b1, 1'b0, 1'b0, 1'b0, 8'h3E, 8'h3E, 1'b0},  // R2 load, enables low
    {1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h3F, 1'b0},  // R3 count
    {1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h40, 1'b0},  // R6 low group wraps, upper advances
    {1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 8'h40, 1'b0},  // R4 en_p low
    {1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h40, 1'b0},  // R4 en_t low
    {1'b1, 1'b0, 1'b1, 1'b1, 8'hFE, 8'hFE, 1'b0},  // R2 load over enables
    {1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'hFF, 1'b1},  // R5 carry at all ones
    {1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b1},  // R5 carry while holding
    {1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'hFF, 1'b0},  // R5 carry gated by en_t
    {1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0},  // R3 wrap to zero
    {1'b1, 1'b0, 1'b0, 1'b1, 8'hA5, 8'hA5, 1'b0}   // R7 bit order of load
  };

  task automatic check(input string req, input logic [TW-1:0] exp_q, input logic exp_c);
    checks++;
    if (q !== exp_q || carry_out !== exp_c) begin
      errors++;
      $display("FAIL %s: q=%h carry=%b expected q=%h carry=%b", req, q, carry_out, exp_q, exp_c);
    end
  endtask

  // drive after the falling edge, sample 1 ns after the following rising edge
  task automatic step(input logic c, input logic l, input logic p, input logic t,
                      input logic [TW-1:0] d);
    @(negedge clk);
    clear_n  = c;
    load_n   = l;
    cnt_en_p = p;
    cnt_en_t = t;
    din      = d;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    clear_n  = 1'b0;
    load_n   = 1'b1;
    cnt_en_p = 1'b0;
    cnt_en_t = 1'b0;
    din      = '0;
    #1;
    check("R1 reset state", 8'h00, 1'b0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][20], VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][16:9]);
      check($sformatf("R1-R7 vector %0d", i), VEC[i][8:1], VEC[i][0]);
    end

    // R1: clear mid-cycle acts before any rising edge
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h5C);
    check("R2 preload", 8'h5C, 1'b0);
    @(negedge clk);
    clear_n = 1'b0;
    #1;
    check("R1 asynchronous clear", 8'h00, 1'b0);

    // R1: clear has priority over load across an edge
    load_n = 1'b0;
    din    = 8'hFF;
    @(posedge clk);
    #1;
    check("R1 clear over load", 8'h00, 1'b0);

    // R5: carry follows en_t within one cycle
    step(1'b1, 1'b0, 1'b0, 1'b1, 8'hFF);
    check("R5 carry at full", 8'hFF, 1'b1);
    @(negedge clk);
    load_n   = 1'b1;
    cnt_en_t = 1'b0;
    #0.5;
    check("R5 carry drops with en_t", 8'hFF, 1'b0);
    cnt_en_t = 1'b1;
    #0.5;
    check("R5 carry returns with en_t", 8'hFF, 1'b1);

    // R8: pulse on en_p between edges has no effect
    step(1'b1, 1'b0, 1'b1, 1'b1, 8'h10);
    check("R8 preload", 8'h10, 1'b0);
    @(negedge clk);
    load_n   = 1'b1;
    cnt_en_p = 1'b0;
    #0.5;
    cnt_en_p = 1'b1;
    @(posedge clk);
    #1;
    check("R8 enable pulse ignored, count taken", 8'h11, 1'b0);
    @(negedge clk);
    cnt_en_p = 1'b1;
    #0.5;
    cnt_en_p = 1'b0;
    @(posedge clk);
    #1;
    check("R8 enable low at edge holds", 8'h11, 1'b0);

    // R6: full cascade run 0..255..0
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'h00);
    check("R6 start at zero", 8'h00, 1'b0);
    @(negedge clk);
    clear_n = 1'b1;
    for (int n = 1; n <= 256; n++) begin
      @(posedge clk);
      #1;
      check("R6 cascade count", TW'(n), (n % 256) == 255);
    end

    finish_run();
  end

endmodule